// File: doc/BRIEF.md
# Two-Channel DMA Register Front End

This block holds the software-visible control and status state of a two-channel scatter-gather DMA engine. A simple 32-bit register bus with separate write and read strobes and a byte address selects one of two channels and, inside that channel, one of four registers: control, status, current descriptor pointer and tail descriptor pointer. Read data is combinational from the addressed register. Read side effects and writes take effect on the next rising clock edge.

Each channel keeps its run/halted/idle state and three pending interrupt bits, and drives one level interrupt. The descriptor engine and the interrupt coalescer report events through single-cycle set pulses. The coalescing countdown and the delay timer count live outside this block and appear in status reads. A write to the tail pointer of channel 0 produces a one-cycle start pulse for the memory-to-stream engine.

Top module: `dma_regfile`

## Requirements
- R1: The channel index is bit 0 of (address / 48). The register offset is (address mod 48). Offsets 0x00–0x03 select control, 0x04–0x07 status, 0x08–0x0B current descriptor, and 0x10–0x13 tail descriptor. Any other offset reads 0, and writes to it change nothing.
- R2: After reset, control reads 0x00010002, and status has halted (bit 0) = 1, idle (bit 1) = 0 and no pending bits. Both descriptor pointers are 0, and irq and mm2s_start are low.
- R3: A control write stores the written value with bit 1 forced to 1. A control read always returns bit 2 as 0.
- R4: When a control write has bit 2 set, or a soft reset is still pending, the channel resets:
  - control becomes 0x00010006;
  - status becomes halted only, with idle cleared and pending bits cleared.
  The reset stays pending until the next control read of that channel. While it is pending, a control write with the run bit set (bit 0) resets again and does not start the channel.
- R5: A control write with bit 0 set and no reset pending or requested clears halted and idle.
- R6: A status read returns the following, with all other bits 0:
  - bits 31:24: that channel's dly_cnt;
  - bits 23:16: that channel's coal_cnt;
  - bits 14:12: the pending bits;
  - bit 1: idle;
  - bit 0: halted.
- R7: A status write clears each pending bit written with 1 and leaves every other status bit unchanged. Halted and idle cannot be written.
- R8: irq_set[3*c+k] sets pending bit 12+k of channel c. halt_set[c] sets halted and idle_set[c] sets idle. A set pulse wins over a software clear of the same bit in the same cycle.
- R9: irq[c] is high exactly when some pending bit of channel c is set together with the same bit of control bits 14:12.
- R10: Descriptor pointer writes store the data with bits 1:0 forced to 0. A tail write clears idle.
- R11: A tail write on channel 0 drives mm2s_start high for the one cycle after the write edge. A tail write on channel 1 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| coal_cnt | input | 16 | Coalescing countdown, 8 bits per channel, channel 0 in low byte |
| dly_cnt | input | 16 | Delay timer count, 8 bits per channel, channel 0 in low byte |
| irq_set | input | 6 | Pending-bit set pulses, 3 per channel |
| halt_set | input | 2 | Halted set pulse per channel |
| idle_set | input | 2 | Idle set pulse per channel |
| irq | output | 2 | Level interrupt per channel |
| mm2s_start | output | 1 | Start pulse for the memory-to-stream engine |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle. They also assume that the status pulses are only sampled at clock edges. The bench keeps to both: it issues exactly one bus operation per cycle, and it drives every pulse in the falling-edge half of the cycle. Random stimulus mixes the following, with pulses often landing in the same cycle as a write:
- addresses beyond the first two windows and at unmapped offsets;
- control values that set the soft-reset bit in only a small fraction of writes, so that runs actually happen;
- random counter inputs.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int ADDR_W = 8,
  parameter logic [7:0] THRESH_INIT = 8'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       coal_cnt,
  input  logic [15:0]       dly_cnt,
  input  logic [5:0]        irq_set,
  input  logic [1:0]        halt_set,
  input  logic [1:0]        idle_set,
  output logic [1:0]        irq,
  output logic              mm2s_start
);
  localparam int WIN = 48;
  localparam logic [31:0] CTRL_RST  = {8'd0, THRESH_INIT, 16'h0002};
  localparam logic [31:0] CTRL_SRST = CTRL_RST | 32'h4;

  logic [1:0][31:0] ctrl_q, ctrl_d, cur_q, cur_d, tail_q, tail_d;
  logic [1:0][2:0]  pend_q, pend_d;
  logic [1:0]       halt_q, halt_d, idle_q, idle_d;
  logic             start_q;

  logic [ADDR_W-1:0] win_idx, off;
  logic              ch;
  logic              hit_ctrl, hit_stat, hit_cur, hit_tail;

  assign win_idx  = bus_addr / ADDR_W'(WIN);
  assign off      = bus_addr % ADDR_W'(WIN);
  assign ch       = win_idx[0];
  assign hit_ctrl = off[5:2] == 4'd0;
  assign hit_stat = off[5:2] == 4'd1;
  assign hit_cur  = off[5:2] == 4'd2;
  assign hit_tail = off[5:2] == 4'd4;

  always_comb begin
    logic [31:0] nv;
    ctrl_d = ctrl_q;
    cur_d  = cur_q;
    tail_d = tail_q;
    pend_d = pend_q;
    halt_d = halt_q;
    idle_d = idle_q;
    for (int c = 0; c < 2; c++) begin
      nv = bus_wdata | 32'h2 | (ctrl_q[c] & 32'h4);
      if (bus_wr && ch == c[0]) begin
        if (hit_ctrl) begin
          if (nv[2]) begin
            ctrl_d[c] = CTRL_SRST;
            halt_d[c] = 1'b1;
            idle_d[c] = 1'b0;
            pend_d[c] = 3'b000;
          end else begin
            ctrl_d[c] = nv;
            if (nv[0]) begin
              halt_d[c] = 1'b0;
              idle_d[c] = 1'b0;
            end
          end
        end
        if (hit_stat) pend_d[c] = pend_q[c] & ~bus_wdata[14:12];
        if (hit_cur)  cur_d[c]  = {bus_wdata[31:2], 2'b00};
        if (hit_tail) begin
          tail_d[c] = {bus_wdata[31:2], 2'b00};
          idle_d[c] = 1'b0;
        end
      end else if (bus_rd && !bus_wr && ch == c[0] && hit_ctrl) begin
        ctrl_d[c][2] = 1'b0;
      end
      pend_d[c] = pend_d[c] | irq_set[3*c +: 3];
      halt_d[c] = halt_d[c] | halt_set[c];
      idle_d[c] = idle_d[c] | idle_set[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= {CTRL_RST, CTRL_RST};
      cur_q   <= '0;
      tail_q  <= '0;
      pend_q  <= '0;
      halt_q  <= 2'b11;
      idle_q  <= 2'b00;
      start_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      cur_q   <= cur_d;
      tail_q  <= tail_d;
      pend_q  <= pend_d;
      halt_q  <= halt_d;
      idle_q  <= idle_d;
      start_q <= bus_wr && !ch && hit_tail;
    end
  end

  always_comb begin
    unique case (off[5:2])
      4'd0:    bus_rdata = ctrl_q[ch] & ~32'h4;
      4'd1:    bus_rdata = {dly_cnt[8*ch +: 8], coal_cnt[8*ch +: 8], 1'b0,
                            pend_q[ch], 10'd0, idle_q[ch], halt_q[ch]};
      4'd2:    bus_rdata = cur_q[ch];
      4'd4:    bus_rdata = tail_q[ch];
      default: bus_rdata = 32'd0;
    endcase
  end

  for (genvar c = 0; c < 2; c++) begin : g_irq
    assign irq[c] = |(pend_q[c] & ctrl_q[c][14:12]);
  end

  assign mm2s_start = start_q;
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [5:0]        irq_set,
  input logic [1:0]        halt_set,
  input logic [1:0]        irq,
  input logic              mm2s_start,
  input logic [1:0][31:0]  ctrl_q,
  input logic [1:0][2:0]   pend_q,
  input logic [1:0]        halt_q
);
  logic [ADDR_W-1:0] a_win, a_off;
  logic a_tail0, a_srst0;
  assign a_win   = bus_addr / ADDR_W'(48);
  assign a_off   = bus_addr % ADDR_W'(48);
  assign a_tail0 = bus_wr && !a_win[0] && a_off[5:2] == 4'd4;
  assign a_srst0 = bus_wr && !a_win[0] && a_off[5:2] == 4'd0 && bus_wdata[2];

  AST_MODE_FORCED: assert property (@(posedge clk) disable iff (!rst_n) ctrl_q[0][1] && ctrl_q[1][1]); // R3
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n) a_srst0 |=> ctrl_q[0][2] && halt_q[0] && ctrl_q[0][0] == 1'b0); // R4
  AST_PEND_SET0: assert property (@(posedge clk) disable iff (!rst_n) (|irq_set[2:0]) |=> (pend_q[0] & $past(irq_set[2:0])) == $past(irq_set[2:0])); // R8
  AST_PEND_SET1: assert property (@(posedge clk) disable iff (!rst_n) (|irq_set[5:3]) |=> (pend_q[1] & $past(irq_set[5:3])) == $past(irq_set[5:3])); // R8
  AST_HALT_SET: assert property (@(posedge clk) disable iff (!rst_n) halt_set[1] |=> halt_q[1]); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (pend_q[0] == 3'b000) |-> !irq[0]); // R9
  AST_START_AFTER: assert property (@(posedge clk) disable iff (!rst_n) a_tail0 |=> mm2s_start); // R11
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) mm2s_start |-> $past(a_tail0)); // R11
endmodule

bind dma_regfile dma_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_set(irq_set), .halt_set(halt_set), .irq(irq),
  .mm2s_start(mm2s_start), .ctrl_q(ctrl_q), .pend_q(pend_q), .halt_q(halt_q)
);

// File: tb/dma_regfile_test.sv
`timescale 1ns/1ps
module dma_regfile_test;
  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] coal_cnt = 0, dly_cnt = 0;
  logic [5:0]  irq_set = 0;
  logic [1:0]  halt_set = 0, idle_set = 0, irq;
  logic        mm2s_start;

  int n_chk = 0, n_err = 0;

  logic [31:0] m_ctrl[2], m_cur[2], m_tail[2];
  logic [2:0]  m_pend[2];
  logic        m_halt[2], m_idle[2];

  dma_regfile uut (.*);

  always #2 clk = ~clk;

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int ch_of(logic [7:0] a); return (a / 48) & 1; endfunction
  function automatic int wd_of(logic [7:0] a); return (a % 48) >> 2; endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    int c = ch_of(a);
    case (wd_of(a))
      0: return m_ctrl[c] & ~32'h4;
      1: return {dly_cnt[8*c +: 8], coal_cnt[8*c +: 8], 1'b0, m_pend[c], 10'd0, m_idle[c], m_halt[c]};
      2: return m_cur[c];
      4: return m_tail[c];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [1:0] exp_irq();
    return {|(m_pend[1] & m_ctrl[1][14:12]), |(m_pend[0] & m_ctrl[0][14:12])};
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_ctrl[c] = 32'h0001_0002; m_cur[c] = 0; m_tail[c] = 0;
      m_pend[c] = 0; m_halt[c] = 1; m_idle[c] = 0;
    end
  endtask

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    int c = ch_of(a);
    logic [31:0] nv;
    case (wd_of(a))
      0: begin
        nv = d | 32'h2 | (m_ctrl[c] & 32'h4);
        if (nv[2]) begin
          m_ctrl[c] = 32'h0001_0006; m_halt[c] = 1; m_idle[c] = 0; m_pend[c] = 0;
        end else begin
          m_ctrl[c] = nv;
          if (nv[0]) begin m_halt[c] = 0; m_idle[c] = 0; end
        end
      end
      1: m_pend[c] &= ~d[14:12];
      2: m_cur[c] = d & ~32'h3;
      4: begin m_tail[c] = d & ~32'h3; m_idle[c] = 0; end
      default: ;
    endcase
  endtask

  task automatic model_sets();
    for (int c = 0; c < 2; c++) begin
      m_pend[c] |= irq_set[3*c +: 3];
      m_halt[c] |= halt_set[c];
      m_idle[c] |= idle_set[c];
    end
  endtask

  task automatic op_write(logic [7:0] a, logic [31:0] d, string tag);
    logic exp_start;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    exp_start = (ch_of(a) == 0) && (wd_of(a) == 4);
    @(posedge clk);
    model_write(a, d);
    model_sets();
    @(negedge clk);
    bus_wr = 0; irq_set = 0; halt_set = 0; idle_set = 0;
    chk({tag, " R11 start"}, {31'd0, mm2s_start}, {31'd0, exp_start});
    chk({tag, " R9 irq"}, {30'd0, irq}, {30'd0, exp_irq()});
  endtask

  task automatic op_read(logic [7:0] a, string tag);
    bus_rd = 1; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp_rd(a));
    @(posedge clk);
    if (wd_of(a) == 0) m_ctrl[ch_of(a)][2] = 1'b0;
    model_sets();
    @(negedge clk);
    bus_rd = 0; irq_set = 0; halt_set = 0; idle_set = 0;
  endtask

  task automatic op_idle(string tag);
    @(posedge clk);
    model_sets();
    @(negedge clk);
    irq_set = 0; halt_set = 0; idle_set = 0;
    chk({tag, " R9 irq"}, {30'd0, irq}, {30'd0, exp_irq()});
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    coal_cnt = 16'hA15A; dly_cnt = 16'h3CC3;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk("R2 irq at reset", {30'd0, irq}, 32'd0);
    chk("R2 start at reset", {31'd0, mm2s_start}, 32'd0);
    for (int c = 0; c < 2; c++) begin
      op_read(8'(c*48 + 0), "R2 ctrl reset");
      op_read(8'(c*48 + 4), "R2 R6 status reset");
      op_read(8'(c*48 + 8), "R2 cur reset");
      op_read(8'(c*48 + 16), "R2 tail reset");
    end

    op_write(8'd0, 32'h0000_7001, "R5 run ch0");
    op_read(8'd0, "R3 ctrl forced bit1");
    op_read(8'd4, "R5 status running");
    op_write(8'd9, 32'h1234_5677, "R10 cur ch0");
    op_read(8'd8, "R10 cur aligned");
    op_write(8'd16 + 48, 32'hDEAD_BEEF, "R11 tail ch1 no start");
    op_read(8'd64, "R10 R1 tail ch1");
    op_write(8'd12, 32'hFFFF_FFFF, "R1 unmapped write");
    op_read(8'd12, "R1 unmapped read");
    op_read(8'd8, "R1 cur untouched");

    irq_set = 6'b000_001; idle_set = 2'b01;
    op_idle("R8 set pulses");
    op_read(8'd4, "R8 status after set");
    op_write(8'd16, 32'h0000_1003, "R10 R11 tail ch0");
    op_read(8'd4, "R10 idle cleared");
    irq_set = 6'b000_001;
    op_write(8'd4, 32'h0000_7003, "R8 R7 set beats clear");
    op_read(8'd4, "R8 pending survives");
    op_write(8'd4, 32'h0000_1003, "R7 w1c");
    op_read(8'd4, "R7 cleared, halted idle kept");

    op_write(8'd48, 32'h0000_0004, "R4 soft reset ch1");
    op_write(8'd48, 32'h0000_7001, "R4 run while pending");
    op_read(8'd52, "R4 still halted");
    op_read(8'd48, "R4 ctrl read clears reset");
    op_write(8'd48, 32'h0000_2001, "R5 run after read");
    op_read(8'd52, "R5 ch1 running");
    op_read(8'd200, "R1 high window maps ch0");

    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 9);
      logic [7:0] a = 8'($urandom_range(0, 255));
      logic [31:0] d = $urandom();
      coal_cnt = 16'($urandom()); dly_cnt = 16'($urandom());
      if ($urandom_range(0, 3) == 0) irq_set = 6'($urandom());
      if ($urandom_range(0, 7) == 0) halt_set = 2'($urandom());
      if ($urandom_range(0, 7) == 0) idle_set = 2'($urandom());
      if ($urandom_range(0, 15) != 0) d[2] = 1'b0;
      if (k < 4) op_write(a, d, "R3 R7 R10 rand write");
      else if (k < 9) op_read(a, "R1 R6 rand read");
      else op_idle("R8 rand idle");
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule